// File: doc/BRIEF.md
# Pixel Palette Lookup and Overlay Merge

This block sits in a display refresh path between the memory fetch logic and the panel or CRT output stage. For every pixel it receives a 16-bit display-memory word, the position of the pixel inside that word, and the colour depth in force. It pulls out the pixel bits and produces a 12-bit RGB value, with 4 bits for each of red, green and blue.

At 1, 2, 4 and 8 bits per pixel, the pixel value is an index. The index selects one 4-bit entry in each of three 256-entry colour tables, one table per primary. At 15 and 16 bits per pixel the tables are bypassed, and each channel takes the top four bits of its field. A monochrome switch turns the output into gray by copying the green channel onto all three channels.

After the colour is formed, a 2-bit cursor or ink-layer code for the same pixel is merged on top. The code can pass the colour through, invert it, or replace it with one of two programmable colours. The host loads the tables and the two overlay colours through a simple single-cycle write port. A valid strobe travels with each pixel through a fixed two-stage pipeline.

Top module: `pal_lookup_merge`

## Requirements
- R1: A pixel presented with `in_valid` high appears on `out_rgb` with `out_valid` high exactly two clock edges later. `out_valid` is low two edges after a cycle with `in_valid` low.
- R2: During reset and after it, and in every cycle where `out_valid` is low, `out_rgb` is 0.
- R3: The `in_mode` codes are 0 = 1 bpp, 1 = 2 bpp, 2 = 4 bpp and 3 = 8 bpp. In these modes, pixel slot 0 occupies the most significant bits of `in_word`, and each following slot sits just below the one before. The slot number is taken modulo the number of pixels per word (16/bpp).
- R4: In the indexed modes, when monochrome is off and the overlay code is 00, `out_rgb` = {red[idx], green[idx], blue[idx]}. Red occupies bits 11:8, green bits 7:4 and blue bits 3:0.
- R5: Mode 4 (15 bpp, layout x-R5-G5-B5, with bit 15 unused) bypasses the tables. Its output is red = word[14:11], green = word[9:6], blue = word[4:1].
- R6: Mode 5 (16 bpp, layout R5-G6-B5) bypasses the tables. Its output is red = word[15:12], green = word[10:7], blue = word[4:1]. Modes 6 and 7 behave as mode 5.
- R7: With `in_mono` high, all three output channels carry the same 4-bit gray value. In indexed modes this value is green[idx]; in modes 4 to 7 it is the green bits given in R5/R6.
- R8: Overlay code 00 passes the colour unchanged. Code 01 outputs the bitwise inverse of all 12 bits.
- R9: Overlay code 10 outputs overlay colour 0 and code 11 outputs overlay colour 1. After reset these colours are 12'h000 and 12'hFFF.
- R10: A write with `wr_tbl` = 0, 1 or 2 stores `wr_data[3:0]` into entry `wr_idx` of the red, green or blue table. With `wr_tbl` = 3, index 0 loads overlay colour 0 and index 1 loads overlay colour 1 from `wr_data`. Other indices are ignored and leave both colours unchanged.
- R11: A write in the same cycle as a pixel's lookup stage (the cycle after that pixel's `in_valid`) does not disturb that pixel, which uses the value held before the write. The next pixel sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel input valid |
| in_word | input | 16 | Display-memory word holding the pixel |
| in_slot | input | 4 | Pixel position within the word, 0 = most significant |
| in_mode | input | 3 | Colour depth code (see R3, R5, R6) |
| in_mono | input | 1 | Monochrome gray output |
| in_ovl | input | 2 | Cursor/ink overlay code for this pixel |
| wr_en | input | 1 | Host write strobe |
| wr_tbl | input | 2 | Write target: 0 red, 1 green, 2 blue, 3 overlay colours |
| wr_idx | input | 8 | Table entry or overlay colour number |
| wr_data | input | 12 | Write data (tables use bits 3:0) |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 12 | Output colour {R, G, B} |

## Verification
The bench builds the block with its default widths: 4-bit channels and 8-bit indices, which gives full 256-entry tables. Every table entry is loaded with a value that depends on its index, so a wrong unpack shift or slot order lands on a visibly different colour. Every pixel slot of every depth code is walked, including the unused codes 6 and 7. These defaults also allow a host write to be placed exactly on a pixel's lookup cycle, and the ignored overlay-colour indices to be exercised.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int WORD_W = 16;
    localparam int CH_W   = 4;
    localparam int IDX_W  = 8;
    localparam int RGB_W  = 3 * CH_W;
    localparam int DEPTH  = 1 << IDX_W;

    typedef enum logic [2:0] {
        PM_1BPP  = 3'd0,
        PM_2BPP  = 3'd1,
        PM_4BPP  = 3'd2,
        PM_8BPP  = 3'd3,
        PM_15BPP = 3'd4,
        PM_16BPP = 3'd5,
        PM_ALT6  = 3'd6,
        PM_ALT7  = 3'd7
    } pix_mode_e;

    typedef enum logic [1:0] {
        OV_PASS   = 2'd0,
        OV_INVERT = 2'd1,
        OV_COLOR0 = 2'd2,
        OV_COLOR1 = 2'd3
    } ovl_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic             bypass;
        logic             mono;
        ovl_e             ovl;
        logic [RGB_W-1:0] direct;
    } stage_t;

    function automatic logic [IDX_W-1:0] unpack_index(
        input logic [WORD_W-1:0] w, input logic [3:0] slot, input pix_mode_e m);
        logic [WORD_W-1:0] s;
        logic [IDX_W-1:0]  r;
        r = '0;
        s = '0;
        case (m)
            PM_1BPP: begin s = w << slot;                 r = IDX_W'(s[15]);    end
            PM_2BPP: begin s = w << {slot[2:0], 1'b0};    r = IDX_W'(s[15:14]); end
            PM_4BPP: begin s = w << {slot[1:0], 2'b00};   r = IDX_W'(s[15:12]); end
            PM_8BPP: begin s = w << {slot[0], 3'b000};    r = IDX_W'(s[15:8]);  end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [RGB_W-1:0] direct_rgb(
        input logic [WORD_W-1:0] w, input pix_mode_e m);
        if (m == PM_15BPP)
            return {w[14:11], w[9:6], w[4:1]};
        return {w[15:12], w[10:7], w[4:1]};
    endfunction

endpackage

// File: rtl/pal_unpack.sv
module pal_unpack
    import pal_pkg::*;
(
    input  logic              valid,
    input  logic [WORD_W-1:0] word,
    input  logic [3:0]        slot,
    input  pix_mode_e         mode,
    input  logic              mono,
    input  ovl_e              ovl,
    output stage_t            st
);
    always_comb begin
        st.valid  = valid;
        st.bypass = (mode >= PM_15BPP);
        st.idx    = unpack_index(word, slot, mode);
        st.direct = direct_rgb(word, mode);
        st.mono   = mono;
        st.ovl    = ovl;
    end
endmodule

// File: rtl/pal_tables.sv
module pal_tables
    import pal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_tbl,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [RGB_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [RGB_W-1:0] rd_rgb,
    output logic [RGB_W-1:0] color0,
    output logic [RGB_W-1:0] color1
);
    localparam int NTBL = 3;

    for (genvar t = 0; t < NTBL; t++) begin : g_tbl
        logic [CH_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en && wr_tbl == 2'(t))
                mem[wr_idx] <= wr_data[CH_W-1:0];
        end
        assign rd_rgb[(NTBL-1-t)*CH_W +: CH_W] = mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            color0 <= '0;
            color1 <= '1;
        end else if (wr_en && wr_tbl == 2'd3) begin
            if (wr_idx == IDX_W'(0)) color0 <= wr_data;
            if (wr_idx == IDX_W'(1)) color1 <= wr_data;
        end
    end

    // R10: overlay colour load and ignored indices
    assert_color0_load_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_tbl == 2'd3 && wr_idx == '0) |=> color0 == $past(wr_data));
    assert_color_ignore_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_tbl == 2'd3 && wr_idx > IDX_W'(1)) |=> ($stable(color0) && $stable(color1)));
endmodule

// File: rtl/pal_merge.sv
module pal_merge
    import pal_pkg::*;
(
    input  stage_t           st,
    input  logic [RGB_W-1:0] tbl_rgb,
    input  logic [RGB_W-1:0] color0,
    input  logic [RGB_W-1:0] color1,
    output logic [RGB_W-1:0] rgb
);
    logic [RGB_W-1:0] base;
    logic [CH_W-1:0]  gray;

    always_comb begin
        base = st.bypass ? st.direct : tbl_rgb;
        gray = base[CH_W +: CH_W];
        if (st.mono)
            base = {gray, gray, gray};
        case (st.ovl)
            OV_PASS:   rgb = base;
            OV_INVERT: rgb = ~base;
            OV_COLOR0: rgb = color0;
            default:   rgb = color1;
        endcase
        if (!st.valid)
            rgb = '0;
    end
endmodule

// File: rtl/pal_lookup_merge.sv
module pal_lookup_merge
    import pal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic [3:0]        in_slot,
    input  logic [2:0]        in_mode,
    input  logic              in_mono,
    input  logic [1:0]        in_ovl,
    input  logic              wr_en,
    input  logic [1:0]        wr_tbl,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [RGB_W-1:0]  wr_data,
    output logic              out_valid,
    output logic [RGB_W-1:0]  out_rgb
);
    stage_t           st_next, st1;
    logic [RGB_W-1:0] tbl_rgb, color0, color1, merged;

    pal_unpack u_unpack (
        .valid (in_valid),
        .word  (in_word),
        .slot  (in_slot),
        .mode  (pix_mode_e'(in_mode)),
        .mono  (in_mono),
        .ovl   (ovl_e'(in_ovl)),
        .st    (st_next)
    );

    always_ff @(posedge clk) begin
        if (rst) st1 <= '0;
        else     st1 <= st_next;
    end

    pal_tables u_tables (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_tbl  (wr_tbl),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (st1.idx),
        .rd_rgb  (tbl_rgb),
        .color0  (color0),
        .color1  (color1)
    );

    pal_merge u_merge (
        .st      (st1),
        .tbl_rgb (tbl_rgb),
        .color0  (color0),
        .color1  (color1),
        .rgb     (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= st1.valid;
            out_rgb   <= merged;
        end
    end

    // R1: valid strobe travels through both stages
    assert_stage1_valid_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> st1.valid);
    assert_out_valid_R1: assert property (@(posedge clk) disable iff (rst)
        st1.valid |=> out_valid);
    assert_out_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !st1.valid |=> !out_valid);
    // R2: idle output is zero
    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> out_rgb == '0);
    // R9: forced colour uses the pre-edge overlay colour
    assert_force_color0_R9: assert property (@(posedge clk) disable iff (rst)
        (st1.valid && st1.ovl == OV_COLOR0) |=> out_rgb == $past(color0));
    // R5: high-colour pass-through
    assert_bypass_R5: assert property (@(posedge clk) disable iff (rst)
        (st1.valid && st1.ovl == OV_PASS && st1.bypass && !st1.mono)
        |=> out_rgb == $past(st1.direct));
endmodule

// File: tb/tb_pal_lookup_merge.sv
module tb_pal_lookup_merge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic [3:0]  in_slot = '0;
    logic [2:0]  in_mode = '0;
    logic        in_mono = 1'b0;
    logic [1:0]  in_ovl = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_tbl = '0;
    logic [7:0]  wr_idx = '0;
    logic [11:0] wr_data = '0;
    logic        out_valid;
    logic [11:0] out_rgb;

    always #4 clk = ~clk;

    pal_lookup_merge dut (.*);

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;
    string tag_ovr = "";

    // reference model state
    int m_r[256], m_g[256], m_b[256];
    int m_c0, m_c1;
    int p_valid, p_word, p_slot, p_mode, p_mono, p_ovl;
    string p_tag;
    int e_valid, e_rgb;
    string e_tag;

    function automatic int model_pix(int word, int slot, int mode, int mono, int ovl);
        int bpp, r, g, b, v, idx, pos;
        case (mode)
            0: bpp = 1; 1: bpp = 2; 2: bpp = 4; 3: bpp = 8; default: bpp = 0;
        endcase
        if (bpp > 0) begin
            pos = slot % (16 / bpp);
            idx = (word >> (16 - bpp * (pos + 1))) & ((1 << bpp) - 1);
            r = m_r[idx]; g = m_g[idx]; b = m_b[idx];
        end else if (mode == 4) begin
            r = (word >> 11) & 15; g = (word >> 6) & 15; b = (word >> 1) & 15;
        end else begin
            r = (word >> 12) & 15; g = (word >> 7) & 15; b = (word >> 1) & 15;
        end
        if (mono != 0) begin r = g; b = g; end
        v = (r << 8) | (g << 4) | b;
        case (ovl)
            1: v = (~v) & 12'hFFF;
            2: v = m_c0;
            3: v = m_c1;
            default: ;
        endcase
        return v;
    endfunction

    function automatic string pick_tag(int mode, int slot, int mono, int ovl);
        if (ovl == 1 || (ovl == 0 && 0)) return "R8";
        if (ovl >= 2) return "R9";
        if (mono != 0) return "R7";
        if (mode == 4) return "R5";
        if (mode >= 5) return "R6";
        if (slot != 0) return "R3";
        return "R4";
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            p_valid = 0; e_valid = 0; e_rgb = 0; e_tag = "R2";
            m_c0 = 0; m_c1 = 12'hFFF;
        end else begin
            e_valid = p_valid;
            e_rgb   = p_valid ? model_pix(p_word, p_slot, p_mode, p_mono, p_ovl) : 0;
            e_tag   = p_valid ? p_tag : "R2";
            p_valid = int'(in_valid);
            p_word = in_word; p_slot = in_slot; p_mode = in_mode;
            p_mono = in_mono; p_ovl = in_ovl;
            p_tag = (tag_ovr != "") ? tag_ovr : pick_tag(in_mode, in_slot, in_mono, in_ovl);
            if (wr_en) begin
                case (wr_tbl)
                    0: m_r[wr_idx] = wr_data & 15;
                    1: m_g[wr_idx] = wr_data & 15;
                    2: m_b[wr_idx] = wr_data & 15;
                    default: begin
                        if (wr_idx == 0) m_c0 = wr_data;
                        if (wr_idx == 1) m_c1 = wr_data;
                    end
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (int'(out_valid) != e_valid) begin
                errors++;
                $display("FAIL R1 out_valid actual %0d expected %0d", out_valid, e_valid);
            end
            checks++;
            if (int'(out_rgb) != e_rgb) begin
                errors++;
                $display("FAIL %s out_rgb actual %03h expected %03h", e_tag, out_rgb, e_rgb);
            end
        end
    end

    task automatic pix(input logic [15:0] w, input int slot, input int mode,
                       input int mono, input int ovl, input bit v = 1);
        @(negedge clk);
        in_valid = v; in_word = w; in_slot = 4'(slot); in_mode = 3'(mode);
        in_mono = 1'(mono); in_ovl = 2'(ovl); wr_en = 1'b0;
    endtask

    task automatic wr(input int tbl, input int idx, input int data);
        @(negedge clk);
        in_valid = 1'b0; wr_en = 1'b1; wr_tbl = 2'(tbl);
        wr_idx = 8'(idx); wr_data = 12'(data);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; wr_en = 1'b0;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            errors++;
            done = 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(4);
        @(negedge clk);
        rst = 1'b0;
        // R2: reset state
        checks++;
        if (out_valid !== 1'b0 || out_rgb !== 12'h000) begin
            errors++;
            $display("FAIL R2 reset out actual %0b/%03h expected 0/000", out_valid, out_rgb);
        end
        // R9: overlay colours after reset
        pix(16'h1234, 0, 5, 0, 2);
        pix(16'h1234, 0, 5, 0, 3);
        idle(3);
        // R10: load all tables with index-dependent values
        for (int i = 0; i < 256; i++) begin
            wr(0, i, i & 15);
            wr(1, i, (i >> 4) ^ 5);
            wr(2, i, (i * 7 + 3) & 15);
        end
        wr(3, 0, 12'h5A3);
        wr(3, 1, 12'h1C7);
        idle(2);
        // R3 R4 R5 R6: walk every slot of every depth code
        for (int m = 0; m < 8; m++)
            for (int s = 0; s < 16; s++)
                pix(16'($urandom), s, m, 0, 0);
        // R7 R8 R9: mixed random stream with gaps
        for (int i = 0; i < 600; i++)
            pix(16'($urandom), $urandom % 16, $urandom % 8, $urandom % 2,
                $urandom % 4, 1'($urandom % 4 != 0));
        idle(3);
        // R10: ignored overlay-colour indices
        tag_ovr = "R10";
        wr(3, 2, 12'h000);
        wr(3, 255, 12'h000);
        pix(16'h0, 0, 3, 0, 2);
        pix(16'h0, 0, 3, 0, 3);
        idle(3);
        // R11: write on the lookup cycle of a pixel
        tag_ovr = "R11";
        wr(0, 8'hAB, 9);
        idle(2);
        pix(16'hAB00, 0, 3, 0, 0);
        wr(0, 8'hAB, 2);
        pix(16'hAB00, 0, 3, 0, 0);
        pix(16'h00AB, 1, 3, 0, 0);
        wr(3, 1, 12'h0F0);
        pix(16'h0, 0, 3, 0, 3);
        idle(4);
        tag_ovr = "";
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule